// File: doc/BRIEF.md
# DMA Buffer Burst Splitter

This block takes one DMA buffer and turns it into a stream of bus beats for an AHB-style master. The buffer is described by a start address, a length in beats and a mode. The block presents each beat on a request/grant handshake. It marks the first beat of every burst and gives that burst's length. The address rises by one beat size for each accepted beat. Incrementing bursts never exceed a fixed maximum, and any shorter remainder is sent as single accesses.

In memory mode the whole buffer is cut straight into bursts and singles. In peripheral mode the buffer is first cut into transactions, and each transaction waits for a request pulse from the peripheral. A transaction is either a single of one beat or a chunk whose length is programmed. Each chunk is then cut into bursts and singles in the same way as a memory buffer. The block acknowledges each transaction and raises a done pulse once the whole buffer has been sent. A new buffer is accepted only while the block is idle.

Top module: `dma_burst_split`

## Requirements
- R1: After reset ready_o is 1, and bus_req_o, done_o and periph_ack_o are 0.
- R2: When load_i is seen while idle, the start address, length and mode are captured. The first beat is presented at start_addr_i. Each beat accepted (bus_req_o and bus_gnt_i both high at a clock edge) raises bus_addr_o by BEAT_BYTES. Exactly len_i beats are accepted per buffer.
- R3: bus_first_o is 1 on the first beat of every burst. Within the current segment (the buffer in memory mode, the transaction in peripheral mode), a burst is MAX_BURST beats when at least MAX_BURST beats remain, and otherwise is one single beat. bus_burst_len_o gives that length on every beat of the burst.
- R4: bus_burst_len_o never exceeds MAX_BURST (16 by default) and is never 0 while bus_req_o is high. Bursts use incrementing addresses.
- R5: In peripheral mode, no beat is requested until periph_req_i is seen while a transaction is pending. periph_req_i is ignored while a transaction is running.
- R6: With chunk_en_i = 0 in peripheral mode, each transaction is exactly one single beat with bus_burst_len_o = 1.
- R7: With chunk_en_i = 1, each transaction is min(chunk length, beats left in the buffer) beats. A chunk length of 0 counts as 1. Chunk length and mode are captured at load.
- R8: periph_ack_o is high for one cycle, in the cycle after the last beat of each peripheral transaction is accepted.
- R9: done_o is high for one cycle, in the cycle after the last beat of the buffer is accepted. ready_o is 1 again in that same cycle.
- R10: A buffer of length 0 gives done_o in the cycle after the load and no beats.
- R11: load_i while not idle has no effect on the beats of the running buffer.
- R12: While bus_req_o is high and bus_gnt_i is low, bus_req_o, bus_addr_o, bus_first_o and bus_burst_len_o hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load a new buffer (taken only when idle) |
| start_addr_i | input | AW | Buffer start byte address |
| len_i | input | LW | Buffer length in beats |
| periph_mode_i | input | 1 | 1: peripheral mode, 0: memory mode |
| chunk_en_i | input | 1 | Peripheral transactions are chunks (1) or singles (0) |
| chunk_len_i | input | CW | Chunk length in beats |
| ready_o | output | 1 | Idle, a buffer may be loaded |
| periph_req_i | input | 1 | Peripheral transaction request |
| periph_ack_o | output | 1 | Transaction complete pulse |
| bus_req_o | output | 1 | Beat request |
| bus_gnt_i | input | 1 | Beat accepted |
| bus_addr_o | output | AW | Beat address |
| bus_first_o | output | 1 | First beat of a burst |
| bus_burst_len_o | output | BLW | Current burst length in beats |
| done_o | output | 1 | Buffer complete pulse |

## Verification
The bench builds the block with its defaults: MAX_BURST of 16, 4-byte beats and 16-bit lengths. A 37-beat buffer therefore yields two full bursts followed by five singles. Chunk lengths of 8, 20 and 0 cover three cases: chunks shorter than a burst, a chunk that holds one full burst plus a tail, and the zero-length chunk rule. A pseudo-random grant pattern with stray peripheral requests and stray loads reaches the stall, ignore and busy-load rules during live bursts.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seg_state_e;
endpackage

// File: rtl/dma_seg_ctrl.sv
module dma_seg_ctrl
  import dma_split_pkg::*;
#(
  parameter int LW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  logic          periph_i,
  input  logic          chunk_en_i,
  input  logic [CW-1:0] chunk_len_i,
  input  logic          preq_i,
  input  logic          beat_acc_i,
  output logic          run_o,
  output logic          idle_o,
  output logic [LW-1:0] seg_rem_o,
  output logic          done_o,
  output logic          ack_o
);
  seg_state_e    state_q;
  logic [LW-1:0] buf_q, seg_q, chunk_eff, xact_len;
  logic          periph_q, chunk_en_q, done_q, ack_q;
  logic [CW-1:0] chunk_len_q;

  always_comb begin
    chunk_eff = (chunk_len_q == '0) ? LW'(1) : LW'(chunk_len_q);
    if (!chunk_en_q) xact_len = LW'(1);
    else             xact_len = (chunk_eff < buf_q) ? chunk_eff : buf_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      buf_q       <= '0;
      seg_q       <= '0;
      periph_q    <= 1'b0;
      chunk_en_q  <= 1'b0;
      chunk_len_q <= '0;
      done_q      <= 1'b0;
      ack_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ack_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (load_i) begin
          buf_q       <= len_i;
          periph_q    <= periph_i;
          chunk_en_q  <= chunk_en_i;
          chunk_len_q <= chunk_len_i;
          if (len_i == '0) done_q <= 1'b1;
          else if (periph_i) state_q <= ST_WAIT;
          else begin
            seg_q   <= len_i;
            state_q <= ST_RUN;
          end
        end
        ST_WAIT: if (preq_i) begin
          seg_q   <= xact_len;
          state_q <= ST_RUN;
        end
        ST_RUN: if (beat_acc_i) begin
          buf_q <= buf_q - 1'b1;
          seg_q <= seg_q - 1'b1;
          if (seg_q == LW'(1)) begin
            ack_q <= periph_q;
            if (buf_q == LW'(1)) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o     = (state_q == ST_RUN);
  assign idle_o    = (state_q == ST_IDLE);
  assign seg_rem_o = seg_q;
  assign done_o    = done_q;
  assign ack_o     = ack_q;

  assert_seg_in_buf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (seg_q != '0 && seg_q <= buf_q));
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> idle_o);
  assert_ack_periph_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> periph_q);
  assert_single_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && periph_q && !chunk_en_q) |-> seg_q == LW'(1));
  assert_busy_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !idle_o) |=> $stable(periph_q) && $stable(chunk_len_q));
endmodule

// File: rtl/dma_burst_gen.sv
module dma_burst_gen #(
  parameter int LW        = 16,
  parameter int MAX_BURST = 16,
  parameter int BLW       = $clog2(MAX_BURST + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [LW-1:0]  seg_rem_i,
  input  logic           beat_acc_i,
  output logic           first_o,
  output logic [BLW-1:0] burst_len_o
);
  logic [BLW-1:0] left_q, cur_len_q, new_len;

  generate
    if (MAX_BURST < 2) begin : g_single_only
      assign new_len = BLW'(1);
    end else begin : g_burst
      assign new_len = (seg_rem_i >= LW'(MAX_BURST)) ? BLW'(MAX_BURST) : BLW'(1);
    end
  endgenerate

  assign first_o     = (left_q == '0);
  assign burst_len_o = first_o ? new_len : cur_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q    <= '0;
      cur_len_q <= BLW'(1);
    end else if (beat_acc_i) begin
      if (first_o) begin
        left_q    <= new_len - 1'b1;
        cur_len_q <= new_len;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assert_burst_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (burst_len_o <= BLW'(MAX_BURST) && burst_len_o != '0));
  assert_burst_fits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !first_o) |-> LW'(left_q) <= seg_rem_i);
  assert_len_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !beat_acc_i) |=> (run_i && $stable(burst_len_o) && $stable(first_o)));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          beat_acc_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] STEP = AW'(BEAT_BYTES);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_q <= '0;
    else if (load_i)     addr_q <= start_addr_i;
    else if (beat_acc_i) addr_q <= addr_q + STEP;
  end

  assign addr_o = addr_q;

  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_acc_i && !load_i) |=> addr_o == $past(addr_o) + STEP);
endmodule

// File: rtl/dma_burst_split.sv
module dma_burst_split #(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int CW         = 8,
  parameter int MAX_BURST  = 16,
  parameter int BEAT_BYTES = 4,
  parameter int BLW        = $clog2(MAX_BURST + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [AW-1:0]  start_addr_i,
  input  logic [LW-1:0]  len_i,
  input  logic           periph_mode_i,
  input  logic           chunk_en_i,
  input  logic [CW-1:0]  chunk_len_i,
  output logic           ready_o,
  input  logic           periph_req_i,
  output logic           periph_ack_o,
  output logic           bus_req_o,
  input  logic           bus_gnt_i,
  output logic [AW-1:0]  bus_addr_o,
  output logic           bus_first_o,
  output logic [BLW-1:0] bus_burst_len_o,
  output logic           done_o
);
  logic          run, idle, beat_acc, load_go;
  logic [LW-1:0] seg_rem;

  assign beat_acc = run & bus_gnt_i;
  assign load_go  = load_i & idle;

  dma_seg_ctrl #(.LW(LW), .CW(CW)) u_seg (
    .clk_i, .rst_ni,
    .load_i(load_i), .len_i(len_i), .periph_i(periph_mode_i),
    .chunk_en_i(chunk_en_i), .chunk_len_i(chunk_len_i),
    .preq_i(periph_req_i), .beat_acc_i(beat_acc),
    .run_o(run), .idle_o(idle), .seg_rem_o(seg_rem),
    .done_o(done_o), .ack_o(periph_ack_o)
  );

  dma_burst_gen #(.LW(LW), .MAX_BURST(MAX_BURST), .BLW(BLW)) u_burst (
    .clk_i, .rst_ni,
    .run_i(run), .seg_rem_i(seg_rem), .beat_acc_i(beat_acc),
    .first_o(bus_first_o), .burst_len_o(bus_burst_len_o)
  );

  dma_addr_gen #(.AW(AW), .BEAT_BYTES(BEAT_BYTES)) u_addr (
    .clk_i, .rst_ni,
    .load_i(load_go), .start_addr_i(start_addr_i),
    .beat_acc_i(beat_acc), .addr_o(bus_addr_o)
  );

  assign ready_o   = idle;
  assign bus_req_o = run;

  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o)));
  assert_ready_no_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && bus_req_o));
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/dma_burst_split_bench.sv
module dma_burst_split_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, LW = 16, CW = 8, MAXB = 16, BB = 4, BLW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 1'b0, periph = 1'b0, chunk_en = 1'b0, preq = 1'b0, gnt = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [LW-1:0] len = '0;
  logic [CW-1:0] chunk_len = '0;
  logic ready, ack, req, first, done;
  logic [AW-1:0] addr;
  logic [BLW-1:0] blen;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_burst_split u_dma_burst_split (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .start_addr_i(st_addr), .len_i(len),
    .periph_mode_i(periph), .chunk_en_i(chunk_en), .chunk_len_i(chunk_len),
    .ready_o(ready), .periph_req_i(preq), .periph_ack_o(ack), .bus_req_o(req),
    .bus_gnt_i(gnt), .bus_addr_o(addr), .bus_first_o(first), .bus_burst_len_o(blen),
    .done_o(done)
  );

  int checks = 0, fails = 0, cyc = 0;
  // reference model state: 0 idle, 1 waiting for peripheral, 2 running
  int m_st = 0, m_buf = 0, m_seg = 0, m_inb = 0, m_blen = 1, m_beats = 0;
  int m_per = 0, m_ce = 0, m_cl = 0;
  longint m_addr = 0;
  bit m_done = 0, m_ack = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      m_done = 0;
      m_ack  = 0;
      case (m_st)
        0: if (load) begin
          m_addr = st_addr; m_buf = len; m_per = periph; m_ce = chunk_en; m_cl = chunk_len;
          m_beats = 0;
          if (len == 0) m_done = 1;
          else if (periph) m_st = 1;
          else begin m_seg = len; m_st = 2; end
        end
        1: if (preq) begin
          if (!m_ce) m_seg = 1;
          else begin
            m_seg = (m_cl == 0) ? 1 : m_cl;
            if (m_seg > m_buf) m_seg = m_buf;
          end
          m_st = 2;
        end
        default: if (gnt) begin
          if (m_inb == 0) begin
            m_blen = (m_seg >= MAXB) ? MAXB : 1;
            m_inb = m_blen - 1;
          end else m_inb--;
          m_addr += BB; m_buf--; m_seg--; m_beats++;
          if (m_seg == 0) begin
            m_ack = (m_per != 0);
            if (m_buf == 0) begin m_done = 1; m_st = 0; end
            else m_st = 1;
          end
        end
      endcase
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int eb;
      eb = (m_inb == 0) ? ((m_seg >= MAXB) ? MAXB : 1) : m_blen;
      chk(ready == (m_st == 0), "R9 ready", ready, m_st == 0);
      chk(req == (m_st == 2), "R5 req", req, m_st == 2);
      chk(done == m_done, "R9 done", done, m_done);
      chk(ack == m_ack, "R8 ack", ack, m_ack);
      if (m_st == 2) begin
        chk(addr == AW'(m_addr), "R2 addr", addr, m_addr);
        chk(first == (m_inb == 0), "R3 first", first, m_inb == 0);
        chk(int'(blen) == eb, "R4 burst_len", blen, eb);
      end
    end
  end

  task automatic run_buf(input logic [AW-1:0] a, input int n, input bit per, input bit ce,
                         input int cl, input bit stall, input bit junk, input string rq);
    @(negedge clk);
    load = 1; st_addr = a; len = LW'(n); periph = per; chunk_en = ce; chunk_len = CW'(cl);
    gnt = 0; preq = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (m_st == 0) break;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gnt  = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      preq = per && (lfsr[2:1] == 2'b00);
      load = junk && lfsr[5];
      st_addr = {lfsr, lfsr}; len = LW'(lfsr[7:0]); periph = lfsr[8];
      chunk_en = lfsr[9]; chunk_len = lfsr[15:8];
    end
    load = 0; preq = 0; gnt = 0;
    chk(m_beats == n, rq, m_beats, n);
    @(negedge clk);
    chk(req == 1'b0 && ready == 1'b1, rq, req, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(req == 1'b0, "R1 req", req, 0);
    chk(done == 1'b0 && ack == 1'b0, "R1 pulses", {done, ack}, 0);
    rst_n = 1;
    run_buf(32'h1000, 37, 0, 0, 0, 0, 0, "R2 mem beats");
    run_buf(32'h2000, 20, 0, 0, 0, 1, 0, "R12 stalled mem");
    run_buf(32'h3000, 0, 0, 0, 0, 0, 0, "R10 zero len");
    run_buf(32'h4000, 3, 1, 0, 0, 1, 0, "R6 single xact");
    run_buf(32'h5000, 20, 1, 1, 8, 1, 1, "R11 chunk8 busy load");
    run_buf(32'h6000, 40, 1, 1, 20, 0, 0, "R7 chunk20");
    run_buf(32'h7000, 3, 1, 1, 0, 1, 0, "R7 chunk0");
    run_buf(32'h8000, 33, 0, 0, 0, 1, 1, "R11 mem busy load");
    run_buf(32'h9000, 16, 1, 1, 16, 1, 0, "R3 exact burst chunk");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule